// File: doc/BRIEF.md
# I2C Target with Selectable Clock Stretching

This block is an I2C target (slave) for 7-bit addressing. It watches the open-drain SCL and SDA lines, answers to its own address, receives and transmits bytes MSB first, and holds SCL low at a chosen point in every byte. While SCL is held, the controller cannot continue, and local software gets time to read the last byte, set up the ACK decision or supply the next byte to send.

Each wait ends in one of two ways: a write of the data register or a strobe on the wait-release input. In transmit mode these two are not the same. A data write sends the written byte next. The strobe instead drops the target out of transmit mode, so it drives no data at all for the following byte. The wait point in a received byte is selectable: the target can hold SCL after the 8th clock, so software can still decide ACK or NACK, or after the 9th clock, when the ACK has already gone out.

The lines are open drain. The block only ever drives a line low through its enable outputs and never drives it high. The bus inputs pass through a synchronizer on the system clock before any use.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, scl_oe, sda_oe, irq, start_seen, stop_seen, ack_seen and tx_mode are all 0.
- R2: start_seen is set and stop_seen cleared when SDA falls while SCL is high. stop_seen is set and start_seen cleared when SDA rises while SCL is high. A stop releases both lines and raises irq.
- R3: The first byte after a start is compared through bits 7:1 with own_addr. On a match the target pulls SDA low on the 9th clock (ACK), whatever ack_en says. On a mismatch it never drives SDA or SCL until the next start, and ack_en has no effect.
- R4: After a matching address byte, the target holds SCL low following the 9th clock and raises irq. tx_mode takes bit 0 of the address byte (1 = controller reads). rx_byte shows the address byte.
- R5: Received data bytes are assembled MSB first into rx_byte. In receive mode, the 9th-clock ACK (SDA low) is driven exactly when ack_en is 1.
- R6: With wait_at_9 = 0, a received data byte stops with SCL held low after the 8th clock, before ACK. ack_en is sampled at the release that ends this wait.
- R7: With wait_at_9 = 1, a received data byte stops with SCL held low after the 9th clock.
- R8: In transmit mode, a data-register write during a wait releases SCL and shifts the written byte out MSB first. Writing 0xFF leaves SDA undriven for the whole byte.
- R9: A wait-release strobe during a transmit wait clears tx_mode and releases SCL. The target then drives no data bits for the following byte.
- R10: In transmit mode, ack_seen records 1 if SDA is low on the 9th clock. After an ACK the target holds SCL and raises irq. After a NACK it holds nothing and drives nothing until the next start or stop.
- R11: irq is a single-cycle pulse, raised on entry to every wait and on a stop.
- R12: A hold on SCL begins only while SCL is already low and lasts until a release. The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own 7-bit address |
| wait_at_9 | input | 1 | Receive wait point: 0 after 8th clock, 1 after 9th clock |
| ack_en | input | 1 | Drive ACK on received data bytes |
| dat_wr | input | 1 | Data register write strobe (releases a wait) |
| dat_wdata | input | 8 | Data written with dat_wr |
| wrel | input | 1 | Wait-release strobe without data |
| rx_byte | output | 8 | Last complete byte seen on the bus |
| start_seen | output | 1 | Start condition detected |
| stop_seen | output | 1 | Stop condition detected |
| ack_seen | output | 1 | SDA was low on the 9th clock of the last transmitted byte |
| tx_mode | output | 1 | Target is transmitting |
| irq | output | 1 | Pulse at each wait entry and at stop |

## Verification
The bench uses the default SYNC_STAGES of 2 and own address 0x2A, and models a stretch-aware controller with a half bit of 16 system clocks. With a short synchronizer, the target's response to an SCL fall (about three clocks) lands inside the low phase. That lets the bench tell the wait after the 8th clock from the wait after the 9th by counting the controller's completed clocks at each interrupt. It also means data bits change well before the next rising edge, so received bytes, read bytes, ACK and NACK outcomes and both release paths can all be observed on the bus.

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       wait_at_9,
  input  logic       ack_en,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  input  logic       wrel,
  output logic [7:0] rx_byte,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       ack_seen,
  output logic       tx_mode,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_p, sda_p;
  logic active, addr_ph, stretch;
  logic [3:0] bitcnt;
  logic [7:0] shreg;

  assign scl_s  = scl_sh[LAST];
  assign sda_s  = sda_sh[LAST];
  assign scl_oe = stretch;

  wire scl_rise   = scl_s & ~scl_p;
  wire scl_fall   = ~scl_s & scl_p;
  wire start_ev   = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev    = scl_s & scl_p & ~sda_p & sda_s;
  wire release_ev = stretch & (dat_wr | wrel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh     <= '1;
      sda_sh     <= '1;
      scl_p      <= 1'b1;
      sda_p      <= 1'b1;
      active     <= 1'b0;
      addr_ph    <= 1'b0;
      stretch    <= 1'b0;
      sda_oe     <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      rx_byte    <= '0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      ack_seen   <= 1'b0;
      tx_mode    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      irq    <= 1'b0;
      if (start_ev) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
        active     <= 1'b1;
        addr_ph    <= 1'b1;
        tx_mode    <= 1'b0;
        bitcnt     <= '0;
        stretch    <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_ev) begin
        stop_seen  <= 1'b1;
        start_seen <= 1'b0;
        active     <= 1'b0;
        tx_mode    <= 1'b0;
        bitcnt     <= '0;
        stretch    <= 1'b0;
        sda_oe     <= 1'b0;
        irq        <= 1'b1;
      end else if (release_ev) begin
        stretch <= 1'b0;
        if (bitcnt == 4'd8) begin
          sda_oe <= ack_en;
        end else if (tx_mode) begin
          if (dat_wr) begin
            shreg  <= dat_wdata;
            sda_oe <= ~dat_wdata[7];
          end else begin
            tx_mode <= 1'b0;
          end
        end
      end else if (active && scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (tx_mode && !addr_ph) ack_seen <= ~sda_s;
        end
      end else if (active && scl_fall) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          if (tx_mode) sda_oe <= ~shreg[7];
        end else if (bitcnt == 4'd8) begin
          rx_byte <= shreg;
          if (addr_ph) begin
            if (shreg[7:1] == own_addr) begin
              sda_oe  <= 1'b1;
              tx_mode <= shreg[0];
            end else begin
              active <= 1'b0;
            end
          end else if (tx_mode) begin
            sda_oe <= 1'b0;
          end else if (!wait_at_9) begin
            stretch <= 1'b1;
            irq     <= 1'b1;
          end else begin
            sda_oe <= ack_en;
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if (addr_ph) begin
            addr_ph <= 1'b0;
            stretch <= 1'b1;
            irq     <= 1'b1;
          end else if (tx_mode) begin
            if (ack_seen) begin
              stretch <= 1'b1;
              irq     <= 1'b1;
            end else begin
              active <= 1'b0;
            end
          end else if (wait_at_9) begin
            stretch <= 1'b1;
            irq     <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_target_chk.sv
module i2c_stretch_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic stop_seen
);
  a_r12_stretch_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_s));

  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r11_irq_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> irq);

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_stretch_target i2c_stretch_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .irq(irq), .stop_seen(stop_seen)
);

// File: tb/tb_i2c_stretch_target.sv
`timescale 1ns/1ps
module tb_i2c_stretch_target;
  localparam int H = 16;

  typedef struct {
    bit          stop;
    logic [7:0]  byt;
    bit          tx;
    int          clks;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, m_scl_lo, m_sda_lo;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe, wait_at_9, ack_en, dat_wr, wrel;
  logic [6:0] own_addr;
  logic [7:0] dat_wdata, rx_byte;
  logic start_seen, stop_seen, ack_seen, tx_mode, irq;

  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_stretch_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
    .wait_at_9(wait_at_9), .ack_en(ack_en), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .wrel(wrel), .rx_byte(rx_byte),
    .start_seen(start_seen), .stop_seen(stop_seen), .ack_seen(ack_seen),
    .tx_mode(tx_mode), .irq(irq)
  );

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0, ctl_clk = 0;
  logic irq_d = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: every interrupt consumes one expected item.
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (q.size() == 0) begin
        check("R11", "unexpected interrupt", 1, 0);
      end else begin
        cur = q.pop_front();
        if (cur.stop) begin
          check(cur.req, "stop flag", stop_seen, 1);
          check(cur.req, "scl free at stop", scl_oe, 0);
        end else begin
          check(cur.req, "stretching", scl_oe, 1);
          check(cur.req, "rx byte", rx_byte, cur.byt);
          check(cur.req, "tx mode", tx_mode, cur.tx);
          check(cur.req, "clocks before wait", ctl_clk, cur.clks);
        end
      end
      if (irq_d) check("R11", "irq width", 2, 1);
    end
    irq_d <= irq;
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic c_start();
    m_sda_lo = 1'b1; wait_h(H);
    m_scl_lo = 1'b1; ctl_clk = 0; wait_h(H);
  endtask

  task automatic c_bit(input bit b, output bit r);
    m_sda_lo = !b; wait_h(H);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_h(H/2); r = sda_bus; wait_h(H/2);
    m_scl_lo = 1'b1; ctl_clk++;
  endtask

  task automatic c_write(input logic [7:0] d, output bit ack);
    bit r;
    ctl_clk = 0;
    for (int i = 7; i >= 0; i--) c_bit(d[i], r);
    c_bit(1'b1, r);
    ack = !r;
    wait_h(H/2);
  endtask

  task automatic c_read(output logic [7:0] d, input bit ack);
    bit r;
    ctl_clk = 0;
    for (int i = 7; i >= 0; i--) begin c_bit(1'b1, r); d[i] = r; end
    c_bit(!ack, r);
    wait_h(H/2);
  endtask

  task automatic c_stop();
    m_sda_lo = 1'b1; wait_h(H);
    m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wait_h(H); m_sda_lo = 1'b0; wait_h(H);
  endtask

  task automatic sw_release(input bit by_data, input logic [7:0] d, input bit ack_val);
    while (scl_oe !== 1'b1) @(negedge clk);
    wait_h(40);
    check("R12", "scl held low during wait", scl_bus, 0);
    ack_en = ack_val;
    if (by_data) begin dat_wdata = d; dat_wr = 1'b1; end
    else wrel = 1'b1;
    @(negedge clk);
    dat_wr = 1'b0; wrel = 1'b0;
    check("R12", "scl freed after release", scl_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("WDOG", "watchdog expired", 1, 0);
    finish_sim();
  end

  initial begin
    bit ack;
    logic [7:0] d;
    rst_n = 1'b0; m_scl_lo = 1'b0; m_sda_lo = 1'b0;
    own_addr = 7'h2A; wait_at_9 = 1'b1; ack_en = 1'b1;
    dat_wr = 1'b0; wrel = 1'b0; dat_wdata = '0;
    wait_h(5); rst_n = 1'b1; wait_h(5);
    check("R1", "scl_oe", scl_oe, 0);
    check("R1", "sda_oe", sda_oe, 0);
    check("R1", "irq", irq, 0);
    check("R1", "start/stop flags", {start_seen, stop_seen}, 0);
    check("R1", "ack/tx flags", {ack_seen, tx_mode}, 0);

    // Write transfer, wait after 9th clock.
    q.push_back('{0, 8'h54, 0, 9, "R4"});
    q.push_back('{0, 8'hA5, 0, 9, "R7"});
    q.push_back('{1, 8'h00, 0, 0, "R2"});
    fork
      begin
        c_start();
        check("R2", "start flag", start_seen, 1);
        check("R2", "stop flag after start", stop_seen, 0);
        c_write(8'h54, ack); check("R3", "address ack", ack, 1);
        c_write(8'hA5, ack); check("R5", "data ack", ack, 1);
        c_stop(); wait_h(6);
        check("R2", "stop flag", stop_seen, 1);
        check("R2", "start flag after stop", start_seen, 0);
      end
      begin
        sw_release(1'b0, 8'h00, 1'b1);
        sw_release(1'b0, 8'h00, 1'b1);
      end
    join

    // Wait after 8th clock, ACK decided during the wait.
    wait_at_9 = 1'b0;
    q.push_back('{0, 8'h54, 0, 9, "R4"});
    q.push_back('{0, 8'h3C, 0, 8, "R6"});
    q.push_back('{0, 8'hC3, 0, 8, "R6"});
    q.push_back('{1, 8'h00, 0, 0, "R2"});
    fork
      begin
        c_start();
        c_write(8'h54, ack); check("R3", "address ack", ack, 1);
        c_write(8'h3C, ack); check("R6", "nack chosen in wait", ack, 0);
        c_write(8'hC3, ack); check("R5", "ack chosen in wait", ack, 1);
        c_stop();
      end
      begin
        sw_release(1'b0, 8'h00, 1'b1);
        sw_release(1'b1, 8'hFF, 1'b0);
        sw_release(1'b1, 8'h00, 1'b1);
      end
    join
    wait_at_9 = 1'b1;

    // Address mismatch: nothing driven, ack_en ignored.
    q.push_back('{1, 8'h00, 0, 0, "R2"});
    c_start();
    c_write(8'h2A, ack); check("R3", "mismatch address nack", ack, 0);
    c_write(8'h00, ack); check("R3", "no ack after mismatch", ack, 0);
    c_stop();

    // Read transfer: data write, 0xFF write, release strobe.
    q.push_back('{0, 8'h55, 1, 9, "R4"});
    q.push_back('{0, 8'h96, 1, 9, "R10"});
    q.push_back('{0, 8'hFF, 1, 9, "R8"});
    q.push_back('{0, 8'hFF, 0, 9, "R9"});
    q.push_back('{1, 8'h00, 0, 0, "R2"});
    fork
      begin
        c_start();
        c_write(8'h55, ack); check("R3", "read address ack", ack, 1);
        c_read(d, 1'b1); check("R8", "byte read", d, 8'h96);
        check("R10", "ack recorded", ack_seen, 1);
        c_read(d, 1'b1); check("R8", "0xFF leaves sda free", d, 8'hFF);
        c_read(d, 1'b1); check("R9", "no data after strobe", d, 8'hFF);
        c_stop();
      end
      begin
        sw_release(1'b1, 8'h96, 1'b1);
        sw_release(1'b1, 8'hFF, 1'b1);
        sw_release(1'b0, 8'h00, 1'b1);
        check("R9", "tx mode cleared", tx_mode, 0);
        sw_release(1'b0, 8'h00, 1'b1);
      end
    join

    // Read ending in NACK.
    q.push_back('{0, 8'h55, 1, 9, "R4"});
    q.push_back('{1, 8'h00, 0, 0, "R2"});
    fork
      begin
        c_start();
        c_write(8'h55, ack);
        c_read(d, 1'b0); check("R8", "byte before nack", d, 8'h81);
        wait_h(10);
        check("R10", "nack recorded", ack_seen, 0);
        check("R10", "no hold after nack", scl_oe, 0);
        check("R10", "sda free after nack", sda_oe, 0);
        c_read(d, 1'b0); check("R10", "silent after nack", d, 8'hFF);
        c_stop();
      end
      begin
        sw_release(1'b1, 8'h81, 1'b1);
      end
    join

    wait_h(20);
    check("R11", "all waits seen", q.size(), 0);
    finish_sim();
  end
endmodule